// File: doc/BRIEF.md
# Shared Mailbox Interrupt Aggregator

This block gathers the empty and full conditions of up to eight shared mailboxes into one 32-bit status word. The empty flags sit in the low byte and the full flags in the byte above. Several shared interrupt lines are produced from that word. Each line has its own 32-bit enable word, and it is raised while any enabled status bit is set. Every source is level-sensitive. An enabled condition keeps its line asserted until the mailbox changes state or software clears the enable bit, so software must mask an empty source once it has served it.

A single-cycle register port gives software access to several registers:
- the per-line enable words;
- the raw status word;
- a pending view, which is the status word masked by the enable word of one line chosen at elaboration;
- a read-only dimensioning word that reports how many units of each kind the surrounding subsystem instantiates.

Top module: `mbox_irq_agg`

## Requirements
- R1: The enable word for shared line x is at byte offset 0x100 + 4*x for x below NUM_OUT. A write there stores all 32 bits, and a read returns the stored value.
- R2: Offset 0x300 reads the status word. Bits [7:0] hold the empty flags of mailboxes 0..7 and bits [15:8] hold their full flags. Bits [31:16] and the flags of mailboxes that are not instantiated read zero. The word reflects the inputs as sampled two clock edges before the read data appears.
- R3: Offset 0x304 reads the status word ANDed with the enable word of line PEND_OUT (default 0).
- R4: irq_out[x] is registered and equals the OR of (status & enable[x]). It stays high for as long as that product is non-zero and falls once the product clears.
- R5: After a synchronous reset, every enable word reads zero, every irq_out bit is low and bus_rdata is zero.
- R6: Offset 0x380 reads a dimensioning word with these 4-bit fields: mailbox count at [3:0], NUM_SS at [7:4], NUM_AS at [11:8], NUM_DB at [15:12] and NUM_OUT at [19:16]. Bits [31:20] read zero. With the default parameters the word is 0x00049328.
- R7: Writes to 0x300, 0x304 and 0x380 are ignored. The status, dimensioning and enable values read back unchanged afterwards.
- R8: A read of an unmapped offset returns zero. A write to an enable slot at or above NUM_OUT (for example 0x110 with four lines) changes no enable word.
- R9: Empty and full bits are masked separately. A line that enables only the full bit of a mailbox does not fire on that mailbox's empty flag, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| mbox_empty | input | NUM_MBOX | Empty flag of each mailbox |
| mbox_full | input | NUM_MBOX | Full flag of each mailbox |
| irq_out | output | NUM_OUT | Level interrupt of each shared line |

## Verification
The mask function is driven with four status patterns against four different enable words:
- a pure-empty set;
- a mix of empty and full that spans both byte lanes;
- a full flag whose mailbox is enabled on a different line;
- the all-quiet case.

Each pattern is checked on every line and through the pending view. Together these separate a wrong byte-lane placement, a wrong line-to-enable pairing and a missing mask. Holding one pattern for several cycles shows that the lines are level outputs and not pulses. Narrowing an enable word while a source is still active shows that masking alone drops the line. Writes to read-only, out-of-range and unmapped offsets are read back through the port to show that they had no effect.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  localparam int MAX_MBOX   = 8;
  localparam int OFS_ENABLE = 'h100;
  localparam int OFS_RAW    = 'h300;
  localparam int OFS_PEND   = 'h304;
  localparam int OFS_DIM    = 'h380;

  // empty flags in the low byte, full flags in the next byte
  function automatic logic [31:0] pack_status(input logic [MAX_MBOX-1:0] emp,
                                              input logic [MAX_MBOX-1:0] ful);
    return {16'h0000, ful, emp};
  endfunction
endpackage

// File: rtl/mbox_irq_status.sv
module mbox_irq_status
  import mbox_irq_pkg::*;
#(
  parameter int NUM_MBOX = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_MBOX-1:0] empty_i,
  input  logic [NUM_MBOX-1:0] full_i,
  output logic [31:0]         stat_o
);
  logic [MAX_MBOX-1:0] emp_ext, ful_ext;

  always_comb begin
    emp_ext = '0;
    ful_ext = '0;
    emp_ext[NUM_MBOX-1:0] = empty_i;
    ful_ext[NUM_MBOX-1:0] = full_i;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_o <= '0;
    else     stat_o <= pack_status(emp_ext, ful_ext);
  end
endmodule

// File: rtl/mbox_irq_enbank.sv
module mbox_irq_enbank
  import mbox_irq_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int ADDR_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_i,
  input  logic [31:0]           wdata_i,
  input  logic [31:0]           stat_i,
  output logic [NUM_OUT*32-1:0] en_flat_o,
  output logic [NUM_OUT-1:0]    irq_o
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_line
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(OFS_ENABLE + 4 * g);
    logic [31:0] en_q;
    logic        irq_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q  <= '0;
        irq_q <= 1'b0;
      end else begin
        if (wr_i && addr_i == SLOT) en_q <= wdata_i;
        irq_q <= |(stat_i & en_q);
      end
    end

    assign en_flat_o[g*32 +: 32] = en_q;
    assign irq_o[g]              = irq_q;
  end
endmodule

// File: rtl/mbox_irq_regif.sv
module mbox_irq_regif
  import mbox_irq_pkg::*;
#(
  parameter int NUM_OUT  = 4,
  parameter int ADDR_W   = 12,
  parameter int PEND_OUT = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           stat_i,
  input  logic [NUM_OUT*32-1:0] en_flat_i,
  input  logic [31:0]           dim_i,
  output logic [31:0]           rdata_o
);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_DIM  = ADDR_W'(OFS_DIM);

  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_RAW)  rd_mux = stat_i;
    if (addr_i == A_PEND) rd_mux = stat_i & en_flat_i[PEND_OUT*32 +: 32];
    if (addr_i == A_DIM)  rd_mux = dim_i;
    for (int g = 0; g < NUM_OUT; g++) begin
      if (addr_i == ADDR_W'(OFS_ENABLE + 4 * g)) rd_mux = en_flat_i[g*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end
endmodule

// File: rtl/mbox_irq_agg.sv
module mbox_irq_agg #(
  parameter int NUM_MBOX = 8,
  parameter int NUM_OUT  = 4,
  parameter int NUM_SS   = 2,
  parameter int NUM_AS   = 3,
  parameter int NUM_DB   = 9,
  parameter int PEND_OUT = 0,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_MBOX-1:0] mbox_empty,
  input  logic [NUM_MBOX-1:0] mbox_full,
  output logic [NUM_OUT-1:0]  irq_out
);
  localparam logic [31:0] DIM_WORD = {12'h000, 4'(NUM_OUT), 4'(NUM_DB),
                                      4'(NUM_AS), 4'(NUM_SS), 4'(NUM_MBOX)};

  logic [31:0]           stat;
  logic [NUM_OUT*32-1:0] en_flat;

  mbox_irq_status #(.NUM_MBOX(NUM_MBOX)) u_status (
    .clk(clk), .rst(rst), .empty_i(mbox_empty), .full_i(mbox_full), .stat_o(stat)
  );

  mbox_irq_enbank #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_enbank (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .wr_i(bus_wr), .wdata_i(bus_wdata),
    .stat_i(stat), .en_flat_o(en_flat), .irq_o(irq_out)
  );

  mbox_irq_regif #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .PEND_OUT(PEND_OUT)) u_regif (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .stat_i(stat), .en_flat_i(en_flat),
    .dim_i(DIM_WORD), .rdata_o(bus_rdata)
  );
endmodule

// File: rtl/mbox_irq_agg_chk.sv
module mbox_irq_agg_chk
  import mbox_irq_pkg::*;
#(
  parameter int NUM_MBOX = 8,
  parameter int NUM_OUT  = 4,
  parameter int NUM_SS   = 2,
  parameter int NUM_AS   = 3,
  parameter int NUM_DB   = 9,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [NUM_MBOX-1:0] mbox_empty,
  input logic [NUM_MBOX-1:0] mbox_full,
  input logic [NUM_OUT-1:0]  irq_out
);
  localparam logic [31:0] DIM_EXP = {12'h000, 4'(NUM_OUT), 4'(NUM_DB),
                                     4'(NUM_AS), 4'(NUM_SS), 4'(NUM_MBOX)};
  logic [MAX_MBOX-1:0] e8, f8;
  logic [31:0]         raw_now;
  logic                mapped;

  always_comb begin
    e8 = '0;
    f8 = '0;
    e8[NUM_MBOX-1:0] = mbox_empty;
    f8[NUM_MBOX-1:0] = mbox_full;
    raw_now = pack_status(e8, f8);
    mapped = (bus_addr == ADDR_W'(OFS_RAW)) || (bus_addr == ADDR_W'(OFS_PEND)) ||
             (bus_addr == ADDR_W'(OFS_DIM));
    for (int g = 0; g < NUM_OUT; g++)
      if (bus_addr == ADDR_W'(OFS_ENABLE + 4 * g)) mapped = 1'b1;
  end

  // R5: leaving reset, every line is low
  a_r5_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> irq_out == '0);

  // R4: with no source active two edges back, no line can be high
  a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
    ($past(raw_now, 2) == '0) |-> irq_out == '0);

  // R2: raw status read matches inputs sampled two edges earlier
  a_r2_raw_read: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(bus_addr) == ADDR_W'(OFS_RAW))
      |-> bus_rdata == $past(raw_now, 2));

  // R3: pending view never shows a bit absent from the status word
  a_r3_pending_subset: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(bus_addr) == ADDR_W'(OFS_PEND))
      |-> (bus_rdata & ~$past(raw_now, 2)) == '0);

  // R6: dimensioning word is constant
  a_r6_dim_word: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) == ADDR_W'(OFS_DIM)) |-> bus_rdata == DIM_EXP);

  // R8: unmapped offsets read zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mapped)) |-> bus_rdata == '0);
endmodule

bind mbox_irq_agg mbox_irq_agg_chk #(
  .NUM_MBOX(NUM_MBOX), .NUM_OUT(NUM_OUT), .NUM_SS(NUM_SS), .NUM_AS(NUM_AS),
  .NUM_DB(NUM_DB), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .mbox_empty(mbox_empty), .mbox_full(mbox_full), .irq_out(irq_out)
);

// File: tb/mbox_irq_agg_tb.sv
module mbox_irq_agg_tb;
  localparam int NUM_MBOX = 8;
  localparam int NUM_OUT  = 4;
  localparam int ADDR_W   = 12;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [ADDR_W-1:0]   bus_addr = '0;
  logic                bus_wr = 1'b0;
  logic [31:0]         bus_wdata = '0;
  logic [31:0]         bus_rdata;
  logic [NUM_MBOX-1:0] mbox_empty = '0;
  logic [NUM_MBOX-1:0] mbox_full = '0;
  logic [NUM_OUT-1:0]  irq_out;

  int checks = 0;
  int errors = 0;

  logic [31:0] en_m [NUM_OUT];
  logic [31:0] raw_m;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_issue = 1'b0;
  logic        rd_issue_d = 1'b0;

  always #5 clk = ~clk;

  mbox_irq_agg u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mbox_empty(mbox_empty), .mbox_full(mbox_full),
    .irq_out(irq_out)
  );

  always @(posedge clk) rd_issue_d <= rd_issue;

  // monitor: compares read data one edge after the read was issued
  always @(negedge clk) begin
    if (rd_issue_d) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s actual=%08h expected=%08h", t, bus_rdata, e);
      end
    end
  end

  task automatic do_read(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    bus_wr   = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_issue = 1'b1;
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = ADDR_W'(a);
    bus_wdata = d;
    bus_wr    = 1'b1;
    for (int g = 0; g < NUM_OUT; g++)
      if (a == 'h100 + 4 * g) en_m[g] = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_in(input logic [7:0] e, input logic [7:0] f);
    @(negedge clk);
    mbox_empty = e;
    mbox_full  = f;
    raw_m = {16'h0, f, e};
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_irq(input string t);
    logic [NUM_OUT-1:0] exp_irq;
    for (int g = 0; g < NUM_OUT; g++) exp_irq[g] = |(raw_m & en_m[g]);
    checks++;
    if (irq_out !== exp_irq) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq_out, exp_irq);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int g = 0; g < NUM_OUT; g++) en_m[g] = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < NUM_OUT; g++) en_m[g] = '0;
    raw_m = '0;
    do_reset();
    // R5 reset state
    check_irq("R5 reset lines");
    do_read('h100, 32'h0, "R5 enable0 after reset");
    do_read('h10C, 32'h0, "R5 enable3 after reset");
    do_read('h300, 32'h0, "R2 raw idle");
    // R6
    do_read('h380, 32'h0004_9328, "R6 dimensioning");
    // R1 enables
    do_write('h100, 32'hFFFF_FFFF);
    do_write('h104, 32'h0000_00F0);
    do_write('h108, 32'h0000_0100);
    do_read('h100, 32'hFFFF_FFFF, "R1 enable0 readback");
    do_read('h104, 32'h0000_00F0, "R1 enable1 readback");
    do_read('h108, 32'h0000_0100, "R1 enable2 readback");
    // pattern A: empties only
    set_in(8'h0F, 8'h00);
    check_irq("R4 pattern empty-low");
    do_read('h300, 32'h0000_000F, "R2 raw empty-low");
    do_read('h304, 32'h0000_000F, "R3 pending empty-low");
    // pattern B: both lanes
    set_in(8'h30, 8'h01);
    check_irq("R4 pattern mixed");
    do_read('h300, 32'h0000_0130, "R2 raw mixed");
    repeat (5) @(negedge clk);
    check_irq("R4 level held");
    // pattern C: full on a mailbox not enabled for line 2
    set_in(8'h00, 8'h02);
    check_irq("R9 full lane separation");
    do_read('h300, 32'h0000_0200, "R2 raw full1");
    // narrowing enable0 to empties drops line 0
    do_write('h100, 32'h0000_00FF);
    @(negedge clk);
    check_irq("R9 empty-only mask ignores full");
    do_read('h304, 32'h0000_0000, "R3 pending masked");
    // R7 read-only offsets
    do_write('h300, 32'hFFFF_FFFF);
    do_write('h304, 32'hFFFF_FFFF);
    do_write('h380, 32'h0000_0000);
    do_read('h300, 32'h0000_0200, "R7 raw unchanged");
    do_read('h380, 32'h0004_9328, "R7 dim unchanged");
    do_read('h100, 32'h0000_00FF, "R7 enable0 unchanged");
    do_read('h104, 32'h0000_00F0, "R7 enable1 unchanged");
    // R8 out of range and unmapped
    do_write('h110, 32'hFFFF_FFFF);
    do_read('h110, 32'h0, "R8 slot beyond lines");
    do_read('h10C, 32'h0, "R8 enable3 untouched");
    do_read('h200, 32'h0, "R8 unmapped");
    check_irq("R8 lines after stray write");
    // quiet inputs
    set_in(8'h00, 8'h00);
    check_irq("R4 lines fall when clear");
    // R5 mid-run reset
    set_in(8'hFF, 8'hFF);
    do_reset();
    @(negedge clk);
    check_irq("R5 lines after second reset");
    do_read('h104, 32'h0, "R5 enable1 after second reset");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule